// File: doc/BRIEF.md
# Layer 3/4 header match filter

This block compares the parsed header fields of each received frame against a small table of programmable filter entries and decides whether the frame is dropped or passed. The header parser presents one frame at a time on a valid strobe. It supplies the IP version, the transport protocol (TCP or UDP), the source and destination addresses and the source and destination ports. One clock later the block returns the decision, together with a vector that shows which entries fired.

Each entry holds a control word, a port word and a 128-bit address made of four 32-bit words. The control word turns on each of the four field comparisons separately: source address, destination address, source port and destination port. Each comparison has its own inverse bit. Each address comparison also has a count of low-order bits to leave out, which gives prefix-style matching. The control word also selects the IP version and the transport protocol that the entry applies to. Configuration arrives through a plain word-write port. A global enable input stands for the filter-enable bit of the packet filter register and gates every entry.

Top module: `hdr_match_filter`

## Requirements
- R1: While reset is asserted and right after it, `dec_valid`, `dec_drop` and `dec_hit` are 0. Reset clears every entry to all-zero words.
- R2: `dec_valid` equals `frm_valid` delayed by one clock. `dec_hit[e]` reports that entry e matched the frame presented in the previous cycle. `dec_drop` is 1 exactly when any bit of `dec_hit` is 1. Several entries may hit at once.
- R3: While `glb_en` is 0 on a frame's cycle, that frame gets `dec_hit` = 0 and `dec_drop` = 0, whatever the entries hold.
- R4: The control word is config word 0, with these bits: 0 = IPv6 select, 2 = source-address enable, 3 = source-address inverse, 4 = destination-address enable, 5 = destination-address inverse, 10:6 = source ignored-bit count, 15:11 = destination ignored-bit count, 16 = UDP select, 18 = source-port enable, 19 = source-port inverse, 20 = destination-port enable, 21 = destination-port inverse. An entry with none of bits 2, 4, 18 and 20 set never hits. This covers the all-zero word.
- R5: An entry hits only when bit 0 equals `frm_ipv6`, bit 16 equals `frm_udp`, and every enabled comparison passes.
- R6: In IPv4 mode, config word 4 is the source address and word 5 is the destination address. They are compared with `frm_src[31:0]` and `frm_dst[31:0]`, and the upper frame bits are ignored. An ignored-bit count N leaves the N least significant bits out of the comparison, and N = 0 compares all 32 bits.
- R7: In IPv6 mode, words 4, 5, 6 and 7 form a 128-bit address, with word 4 as bits 31:0 and word 7 as bits 127:96. If the source enable is set, the address is compared with `frm_src` using the source count and the source inverse bit. Otherwise, if the destination enable is set, it is compared with `frm_dst` using the destination fields. When both enables are set, only the source comparison counts.
- R8: Config word 1 is the port word: bits 31:16 hold the destination port and bits 15:0 hold the source port. Both are compared exactly with `frm_dport` and `frm_sport`.
- R9: An inverse bit turns its field's pass into a fail and its fail into a pass.
- R10: Writes to config words 2 and 3 have no effect on any decision.
- R11: A config write and a frame in the same cycle: the frame is judged with the configuration held before that write. The write applies to the following frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global filter enable |
| cfg_we | input | 1 | Config word write strobe |
| cfg_entry | input | SEL_W | Entry being written |
| cfg_word | input | 3 | Word index: 0 control, 1 ports, 4..7 address |
| cfg_wdata | input | 32 | Write data |
| frm_valid | input | 1 | Frame header fields valid this cycle |
| frm_ipv6 | input | 1 | Frame is IPv6 |
| frm_udp | input | 1 | Frame transport is UDP (else TCP) |
| frm_src | input | 128 | Source address (IPv4 in bits 31:0) |
| frm_dst | input | 128 | Destination address (IPv4 in bits 31:0) |
| frm_sport | input | 16 | Source port |
| frm_dport | input | 16 | Destination port |
| dec_valid | output | 1 | Decision valid |
| dec_drop | output | 1 | Frame is dropped |
| dec_hit | output | ENTRIES | Per-entry hit vector |

## Verification
A configuration write and a frame evaluation can land on the same clock edge. Both the entry registers and the decision register are loaded on that edge. The bench provokes this by raising `cfg_we` and `frm_valid` together. The write rewrites an entry so that the frame would be judged the other way, and the bench expects the decision from the old contents. A following frame then has to reflect the new contents. The bulk sweep rewrites one entry per round while the others keep their earlier random settings, so hits from several entries and from stale entries are also judged against the arithmetic model.

// File: rtl/hdr_match_filter.sv
module hdr_match_filter #(
  parameter int ENTRIES = 4,
  localparam int SEL_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_entry,
  input  logic [2:0]         cfg_word,
  input  logic [31:0]        cfg_wdata,
  input  logic               frm_valid,
  input  logic               frm_ipv6,
  input  logic               frm_udp,
  input  logic [127:0]       frm_src,
  input  logic [127:0]       frm_dst,
  input  logic [15:0]        frm_sport,
  input  logic [15:0]        frm_dport,
  output logic               dec_valid,
  output logic               dec_drop,
  output logic [ENTRIES-1:0] dec_hit
);

  typedef struct packed {
    logic       dp_inv;
    logic       dp_en;
    logic       sp_inv;
    logic       sp_en;
    logic       l4_udp;
    logic [4:0] da_cnt;
    logic [4:0] sa_cnt;
    logic       da_inv;
    logic       da_en;
    logic       sa_inv;
    logic       sa_en;
    logic       l3_v6;
  } ctl_t;

  ctl_t         ctl_q  [ENTRIES];
  logic [31:0]  port_q [ENTRIES];
  logic [127:0] addr_q [ENTRIES];
  logic [ENTRIES-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        ctl_q[e]  <= '0;
        port_q[e] <= '0;
        addr_q[e] <= '0;
      end
    end else if (cfg_we && int'(cfg_entry) < ENTRIES) begin
      case (cfg_word)
        3'd0: ctl_q[cfg_entry] <= '{dp_inv: cfg_wdata[21], dp_en: cfg_wdata[20],
                                    sp_inv: cfg_wdata[19], sp_en: cfg_wdata[18],
                                    l4_udp: cfg_wdata[16],
                                    da_cnt: cfg_wdata[15:11], sa_cnt: cfg_wdata[10:6],
                                    da_inv: cfg_wdata[5], da_en: cfg_wdata[4],
                                    sa_inv: cfg_wdata[3], sa_en: cfg_wdata[2],
                                    l3_v6: cfg_wdata[0]};
        3'd1: port_q[cfg_entry] <= cfg_wdata;
        3'd4: addr_q[cfg_entry][31:0]   <= cfg_wdata;
        3'd5: addr_q[cfg_entry][63:32]  <= cfg_wdata;
        3'd6: addr_q[cfg_entry][95:64]  <= cfg_wdata;
        3'd7: addr_q[cfg_entry][127:96] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    ctl_t         c;
    logic [31:0]  m_sa, m_da;
    logic [127:0] a6, m6;
    logic [4:0]   n6;
    logic         sa4, da4, eq6, inv6, l3_ok, sp_ok, dp_ok, active, proto;

    assign c    = ctl_q[g];
    assign m_sa = 32'hFFFF_FFFF << c.sa_cnt;
    assign m_da = 32'hFFFF_FFFF << c.da_cnt;
    assign sa4  = ((frm_src[31:0] ^ addr_q[g][31:0])  & m_sa) == '0;
    assign da4  = ((frm_dst[31:0] ^ addr_q[g][63:32]) & m_da) == '0;

    assign a6   = c.sa_en ? frm_src  : frm_dst;
    assign n6   = c.sa_en ? c.sa_cnt : c.da_cnt;
    assign inv6 = c.sa_en ? c.sa_inv : c.da_inv;
    assign m6   = {128{1'b1}} << n6;
    assign eq6  = ((a6 ^ addr_q[g]) & m6) == '0;

    assign l3_ok = c.l3_v6 ? (!(c.sa_en || c.da_en) || (eq6 ^ inv6))
                           : ((!c.sa_en || (sa4 ^ c.sa_inv)) && (!c.da_en || (da4 ^ c.da_inv)));
    assign sp_ok = !c.sp_en || ((frm_sport == port_q[g][15:0])  ^ c.sp_inv);
    assign dp_ok = !c.dp_en || ((frm_dport == port_q[g][31:16]) ^ c.dp_inv);

    assign active = c.sa_en || c.da_en || c.sp_en || c.dp_en;
    assign proto  = (c.l3_v6 == frm_ipv6) && (c.l4_udp == frm_udp);
    assign hit[g] = active && proto && l3_ok && sp_ok && dp_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_drop  <= 1'b0;
      dec_hit   <= '0;
    end else begin
      dec_valid <= frm_valid;
      dec_hit   <= (frm_valid && glb_en) ? hit : '0;
      dec_drop  <= frm_valid && glb_en && (hit != '0);
    end
  end

endmodule

// File: rtl/hdr_match_filter_chk.sv
module hdr_match_filter_chk #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glb_en,
  input logic               frm_valid,
  input logic               dec_valid,
  input logic               dec_drop,
  input logic [ENTRIES-1:0] dec_hit
);

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dec_valid == $past(frm_valid)));

  assert_drop_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_drop |-> dec_valid);

  assert_hit_implies_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit != '0) |-> dec_drop);

  assert_idle_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (dec_hit == '0));

  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !glb_en) |=> (!dec_drop && dec_hit == '0));

endmodule

bind hdr_match_filter hdr_match_filter_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/test_hdr_match_filter.sv
module test_hdr_match_filter;
  localparam int N = 4;

  logic clk = 0, rst_n = 0, glb_en = 0, cfg_we = 0;
  logic [1:0] cfg_entry = 0;
  logic [2:0] cfg_word = 0;
  logic [31:0] cfg_wdata = 0;
  logic frm_valid = 0, f_v6 = 0, f_udp = 0;
  logic [127:0] f_src = 0, f_dst = 0;
  logic [15:0] f_sp = 0, f_dp = 0;
  logic dec_valid, dec_drop;
  logic [N-1:0] dec_hit;

  int total = 0, bad = 0;
  logic [31:0] m_ctl [N];
  logic [31:0] m_prt [N];
  logic [31:0] m_adr [N][4];
  logic [31:0] rs = 32'h1234_5678;

  always #5 clk = ~clk;

  hdr_match_filter #(.ENTRIES(N)) i_hdr_match_filter (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cfg_we(cfg_we), .cfg_entry(cfg_entry),
    .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_ipv6(f_v6),
    .frm_udp(f_udp), .frm_src(f_src), .frm_dst(f_dst), .frm_sport(f_sp), .frm_dport(f_dp),
    .dec_valid(dec_valid), .dec_drop(dec_drop), .dec_hit(dec_hit));

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic logic [31:0] mk_ctl(logic v6, logic sae, logic sai, logic dae, logic dai,
                                         logic [4:0] nsa, logic [4:0] nda, logic udp,
                                         logic spe, logic spi, logic dpe, logic dpi);
    logic [31:0] w = '0;
    w[0] = v6; w[2] = sae; w[3] = sai; w[4] = dae; w[5] = dai;
    w[10:6] = nsa; w[15:11] = nda; w[16] = udp;
    w[18] = spe; w[19] = spi; w[20] = dpe; w[21] = dpi;
    return w;
  endfunction

  function automatic void mdl_wr(int e, int w, logic [31:0] d);
    if (w == 0) m_ctl[e] = d;
    else if (w == 1) m_prt[e] = d;
    else if (w >= 4) m_adr[e][w-4] = d;
  endfunction

  function automatic logic fld(logic eq, logic inv);
    return inv ? !eq : eq;
  endfunction

  function automatic logic [N-1:0] exp_hits();
    logic [N-1:0] h = '0;
    for (int e = 0; e < N; e++) begin
      logic [31:0] c = m_ctl[e];
      logic [127:0] a = {m_adr[e][3], m_adr[e][2], m_adr[e][1], m_adr[e][0]};
      int nsa = int'(c[10:6]);
      int nda = int'(c[15:11]);
      logic ok = 1'b1;
      if (!(c[2] | c[4] | c[18] | c[20])) continue;
      if (c[0] != f_v6 || c[16] != f_udp) continue;
      if (c[0]) begin
        if (c[2]) ok &= fld((f_src >> nsa) == (a >> nsa), c[3]);
        else if (c[4]) ok &= fld((f_dst >> nda) == (a >> nda), c[5]);
      end else begin
        if (c[2]) ok &= fld((f_src[31:0] >> nsa) == (m_adr[e][0] >> nsa), c[3]);
        if (c[4]) ok &= fld((f_dst[31:0] >> nda) == (m_adr[e][1] >> nda), c[5]);
      end
      if (c[18]) ok &= fld(f_sp == m_prt[e][15:0], c[19]);
      if (c[20]) ok &= fld(f_dp == m_prt[e][31:16], c[21]);
      h[e] = ok;
    end
    return glb_en ? h : '0;
  endfunction

  task automatic wr(int e, int w, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_entry = 2'(e); cfg_word = 3'(w); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    mdl_wr(e, w, d);
  endtask

  task automatic judge(string tag, logic [N-1:0] eh);
    logic ed = (eh != '0);
    total++;
    if (dec_valid !== 1'b1 || dec_hit !== eh || dec_drop !== ed) begin
      bad++;
      $display("FAIL %s: valid=%b hit=%b drop=%b expected valid=1 hit=%b drop=%b",
               tag, dec_valid, dec_hit, dec_drop, eh, ed);
    end
  endtask

  task automatic frame(string tag);
    logic [N-1:0] eh;
    @(negedge clk);
    frm_valid = 1;
    eh = exp_hits();
    @(negedge clk);
    frm_valid = 0;
    judge(tag, eh);
  endtask

  task automatic frame_and_write(string tag, int e, int w, logic [31:0] d);
    logic [N-1:0] eh;
    @(negedge clk);
    frm_valid = 1;
    cfg_we = 1; cfg_entry = 2'(e); cfg_word = 3'(w); cfg_wdata = d;
    eh = exp_hits();
    @(negedge clk);
    frm_valid = 0; cfg_we = 0;
    mdl_wr(e, w, d);
    judge(tag, eh);
  endtask

  task automatic clear_all();
    for (int e = 0; e < N; e++) wr(e, 0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < N; e++) begin
      m_ctl[e] = 0; m_prt[e] = 0;
      for (int w = 0; w < 4; w++) m_adr[e][w] = 0;
    end
    repeat (3) @(negedge clk);
    total++;
    if (dec_valid !== 0 || dec_drop !== 0 || dec_hit !== 0) begin
      bad++;
      $display("FAIL R1: valid=%b drop=%b hit=%b expected 0 0 0", dec_valid, dec_drop, dec_hit);
    end
    rst_n = 1;
    glb_en = 1;
    @(negedge clk);
    total++;
    if (dec_valid !== 0 || dec_drop !== 0 || dec_hit !== 0) begin
      bad++;
      $display("FAIL R1: after reset valid=%b drop=%b hit=%b expected 0 0 0", dec_valid, dec_drop, dec_hit);
    end
    f_src = 128'h0; f_dst = 128'h0; f_sp = 0; f_dp = 0;
    frame("R1 zero entries pass");

    // R4: protocol select alone does not activate an entry
    wr(0, 0, mk_ctl(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    f_v6 = 1; f_udp = 0;
    frame("R4 no enable no hit");

    // R6: IPv4 source prefix with 8 ignored bits
    wr(0, 4, 32'h0A00_0105);
    wr(0, 0, mk_ctl(0, 1, 0, 0, 0, 5'd8, 0, 0, 0, 0, 0, 0));
    f_v6 = 0; f_src = {96'hDEAD, 32'h0A00_01FF};
    frame("R6 src prefix hit");
    f_src = {96'h0, 32'h0A00_0205};
    frame("R6 src prefix miss");
    wr(0, 5, 32'hC0A8_0001);
    wr(0, 0, mk_ctl(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    f_dst = {96'h0, 32'hC0A8_0001};
    frame("R6 dst exact hit");
    f_dst = {96'h0, 32'hC0A8_0000};
    frame("R6 dst exact miss");

    // R5: transport select mismatch
    f_udp = 1;
    frame("R5 udp mismatch");
    f_udp = 0; f_v6 = 1;
    frame("R5 ipv6 mismatch");
    f_v6 = 0;

    // R8, R9: ports and inversion
    wr(1, 1, {16'd443, 16'd5000});
    wr(1, 0, mk_ctl(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 0));
    f_udp = 1; f_sp = 16'd5000; f_dp = 16'd443;
    frame("R8 both ports hit");
    f_dp = 16'd444;
    frame("R8 dst port miss");
    wr(1, 0, mk_ctl(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 1));
    frame("R9 inverse dst port hit");
    f_dp = 16'd443;
    frame("R9 inverse dst port miss");

    // R10: words 2 and 3 do nothing
    f_dp = 16'd444;
    wr(1, 2, 32'hFFFF_FFFF);
    wr(1, 3, 32'h0000_0000);
    frame("R10 ignored words");

    // R2: two entries hit together
    wr(2, 1, {16'd444, 16'd7});
    wr(2, 0, mk_ctl(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0));
    frame("R2 multi hit");

    // R3: global enable off
    glb_en = 0;
    frame("R3 gated off");
    glb_en = 1;

    // R7: IPv6 with both enables, source wins
    clear_all();
    wr(3, 4, 32'h0000_0001); wr(3, 5, 32'h0000_0002);
    wr(3, 6, 32'h0000_0003); wr(3, 7, 32'h2001_0DB8);
    wr(3, 0, mk_ctl(1, 1, 0, 1, 0, 5'd4, 0, 0, 0, 0, 0, 0));
    f_v6 = 1; f_udp = 0;
    f_src = {32'h2001_0DB8, 32'h3, 32'h2, 32'h0000_000E};
    f_dst = 128'h5;
    frame("R7 v6 source used");
    f_dst = f_src; f_src = 128'h5;
    frame("R7 v6 dest ignored when src set");

    // R11: write in the same cycle as a frame
    f_src = {32'h2001_0DB8, 32'h3, 32'h2, 32'h0000_0001};
    frame_and_write("R11 old config judged", 3, 0, 32'h0);
    frame("R11 new config applied");

    // R2 sweep over control combinations
    for (int i = 0; i < 1024; i++) begin
      int e = i % N;
      logic [31:0] r = rnd();
      logic [9:0] b = 10'(i);
      wr(e, 0, mk_ctl(b[8], b[0], b[4], b[1], b[5], r[4:0], r[9:5], b[9], b[2], b[6], b[3], b[7]));
      wr(e, 1, rnd());
      for (int w = 4; w < 8; w++) wr(e, w, rnd());
      for (int k = 0; k < 4; k++) begin
        logic [127:0] base = {m_adr[e][3], m_adr[e][2], m_adr[e][1], m_adr[e][0]};
        logic [127:0] d1 = (k == 1) ? (128'd1 << r[16:12]) : (k == 2) ? (128'd1 << (r[11] ? 31 : 100)) : 128'd0;
        logic [127:0] d2 = (k == 2) ? (128'd1 << r[21:17]) : (k == 3) ? (128'd1 << 31) : 128'd0;
        f_v6 = (k == 3) ? ~b[8] : b[8];
        f_udp = (k == 2 && r[10]) ? ~b[9] : b[9];
        if (f_v6) begin
          f_src = base ^ d1;
          f_dst = base ^ d2;
        end else begin
          f_src = {rnd(), rnd(), rnd(), m_adr[e][0] ^ d1[31:0]};
          f_dst = {rnd(), rnd(), rnd(), m_adr[e][1] ^ d2[31:0]};
        end
        f_sp = m_prt[e][15:0] ^ ((k == 2) ? 16'h1 : 16'h0);
        f_dp = m_prt[e][31:16] ^ ((k == 1 && r[22]) ? 16'h0100 : 16'h0);
        frame("R2 sweep");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule